// File: doc/BRIEF.md
# Per-Core Compare Timer

This block pairs a free-running 64-bit system counter with one physical compare timer for a single core. Software reaches it through a small register port: one write strobe, one address, a 64-bit write bus and a combinational read bus. The counter advances once for each clock cycle in which the count-enable strobe is high. The timer compares the count against a programmed 64-bit value and keeps a status flag. It drives a level interrupt while that flag is set and the timer is enabled and unmasked.

There are two ways to program the compare point. The first is an absolute 64-bit value. The second is a signed 32-bit distance from the current count. Every compare write re-evaluates the status flag in the same cycle. The status flag lives apart from the enable and mask bits, and software cannot write it. Apart from the six registers in the map below, every address reads as zero and ignores writes. These spare addresses stand in for timer kinds this block does not provide.

Register map (4-bit address): 0 frequency, 1 kernel control, 2 compare, 3 down-count view, 4 control, 5 count. Addresses 6 to 15 are unimplemented.

Top module: `core_cmp_timer`

## Requirements
- R1: After reset the registers read as follows: frequency 0x01800000, kernel control 0, compare 0, count 0. Control bits 1:0 read 0.
- R2: The count at address 5 rises by one on each clock edge where `cnt_en` is high and holds when `cnt_en` is low.
- R3: A write to the compare register at address 2 loads all 64 bits and re-evaluates status at once. Status becomes 1 if the current count is greater than or equal to the new compare value, and 0 otherwise. The compare register reads back the stored value.
- R4: A write to address 3 sets compare to the current count plus wdata[31:0], sign-extended to 64 bits. Status is re-evaluated as in R3. A read of address 3 returns, zero-extended, the low 32 bits of compare minus the current count.
- R5: Once the count reaches or passes compare, status (control bit 2) becomes 1 on the next clock edge, whether or not the timer is enabled. Status then stays 1 until a compare write re-evaluates it.
- R6: `irq` equals status AND enable AND NOT mask, with no register stage between the control and status state and the pin.
- R7: A write to the control register at address 4 updates only enable (bit 0) and mask (bit 1). Bit 2 of wdata has no effect on status, and the register reads back {status, mask, enable} in bits 2:0.
- R8: Writes to the count at address 5 are ignored.
- R9: Addresses 6 to 15 read as 0, and writes to them change no implemented register.
- R10: The frequency register (address 0) and the kernel-control register (address 1) each store the low 32 bits of a write and read them back, zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_en | input | 1 | Count-enable strobe; the counter steps once per high cycle |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register address |
| wdata | input | 64 | Write data |
| rdata | output | 64 | Read data for `addr`, combinational |
| irq | output | 1 | Level timer interrupt |

## Verification
The bench sweeps signed deltas from -8 to +8 through the down-count register and checks the compare, status and down-count readback for each. A design that forgot to sign-extend would put negative deltas about four billion counts into the future and would leave status clear. Status must set while the timer is disabled and must survive a control write that carries bit 2 clear. A design that tied status to enable, or let control writes reach it, would lose the event or erase it. The bench steps through all eight control codes with status both clear and set to check the interrupt gating. It also writes every unimplemented address and the count register, then confirms that no stored register moved.

// File: rtl/ctmr_pkg.sv
package ctmr_pkg;

  localparam int unsigned ADDR_W = 4;

  typedef enum logic [ADDR_W-1:0] {
    A_FREQ  = 4'd0,
    A_KCTL  = 4'd1,
    A_CVAL  = 4'd2,
    A_TVAL  = 4'd3,
    A_CTL   = 4'd4,
    A_COUNT = 4'd5
  } reg_addr_e;

  typedef struct packed {
    logic istatus;
    logic imask;
    logic enable;
  } ctl_t;

  localparam logic [31:0] FREQ_RESET = 32'h0180_0000;

endpackage

// File: rtl/ctmr_rst_sync.sv
module ctmr_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/ctmr_counter.sv
module ctmr_counter #(
  parameter int unsigned CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             cnt_en,
  output logic [CNT_W-1:0] count
);

  logic [CNT_W-1:0] count_q;
  logic [CNT_W-1:0] count_d;

  always_comb begin
    count_d = count_q + {{(CNT_W-1){1'b0}}, 1'b1};
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)     count_q <= '0;
    else if (cnt_en) count_q <= count_d;
  end

  assign count = count_q;

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_ni)
    cnt_en |=> (count == $past(count) + 1'b1)); // R2
  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_ni)
    !cnt_en |=> $stable(count)); // R2

endmodule

// File: rtl/ctmr_cfgregs.sv
module ctmr_cfgregs #(
  parameter int unsigned REG_W = 32
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             freq_wr,
  input  logic             kctl_wr,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] freq,
  output logic [REG_W-1:0] kctl
);
  import ctmr_pkg::*;

  logic [REG_W-1:0] freq_q;
  logic [REG_W-1:0] kctl_q;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)      freq_q <= REG_W'(FREQ_RESET);
    else if (freq_wr) freq_q <= wdata;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)      kctl_q <= '0;
    else if (kctl_wr) kctl_q <= wdata;
  end

  assign freq = freq_q;
  assign kctl = kctl_q;

  AST_FREQ_KEEP: assert property (@(posedge clk) disable iff (!rst_ni)
    !freq_wr |=> $stable(freq)); // R10
  AST_KCTL_KEEP: assert property (@(posedge clk) disable iff (!rst_ni)
    !kctl_wr |=> $stable(kctl)); // R10

endmodule

// File: rtl/ctmr_compare.sv
module ctmr_compare #(
  parameter int unsigned CNT_W = 64,
  parameter int unsigned TV_W  = 32
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] count,
  input  logic             cval_wr,
  input  logic             tval_wr,
  input  logic             ctl_wr,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] cval,
  output logic [TV_W-1:0]  tval,
  output ctmr_pkg::ctl_t   ctl,
  output logic             irq
);
  import ctmr_pkg::*;

  localparam int unsigned EXT_W = CNT_W - TV_W;

  logic [CNT_W-1:0] cmp_q, cmp_d, cmp_new, delta;
  logic [CNT_W-1:0] remain;
  logic             cmp_load;
  logic             status_q, status_d;
  logic             en_q, en_d, mask_q, mask_d;

  always_comb begin
    delta    = {{EXT_W{wdata[TV_W-1]}}, wdata[TV_W-1:0]};
    cmp_load = cval_wr | tval_wr;
    cmp_new  = cval_wr ? wdata : (count + delta);
    cmp_d    = cmp_load ? cmp_new : cmp_q;
    if (cmp_load) status_d = (count >= cmp_new);
    else          status_d = status_q | (count >= cmp_q);
    en_d     = ctl_wr ? wdata[0] : en_q;
    mask_d   = ctl_wr ? wdata[1] : mask_q;
    remain   = cmp_q - count;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)       cmp_q <= '0;
    else if (cmp_load) cmp_q <= cmp_d;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) status_q <= 1'b0;
    else         status_q <= status_d;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      mask_q <= 1'b0;
    end else if (ctl_wr) begin
      en_q   <= en_d;
      mask_q <= mask_d;
    end
  end

  assign cval        = cmp_q;
  assign tval        = remain[TV_W-1:0];
  assign ctl.istatus = status_q;
  assign ctl.imask   = mask_q;
  assign ctl.enable  = en_q;
  assign irq         = status_q & en_q & ~mask_q;

  AST_STATUS_ON_LOAD: assert property (@(posedge clk) disable iff (!rst_ni)
    cmp_load |=> (status_q == ($past(count) >= cmp_q))); // R3
  AST_STATUS_REACH: assert property (@(posedge clk) disable iff (!rst_ni)
    (!cmp_load && (count >= cmp_q)) |=> status_q); // R5
  AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_ni)
    (status_q && !cmp_load) |=> status_q); // R5
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_ni)
    irq |-> (ctl.enable && !ctl.imask && ctl.istatus)); // R6
  AST_CTL_KEEP: assert property (@(posedge clk) disable iff (!rst_ni)
    !ctl_wr |=> ($stable(en_q) && $stable(mask_q))); // R7

endmodule

// File: rtl/core_cmp_timer.sv
module core_cmp_timer #(
  parameter int unsigned CNT_W = 64,
  parameter int unsigned TV_W  = 32,
  parameter int unsigned REG_W = 32
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        cnt_en,
  input  logic                        wr_en,
  input  logic [ctmr_pkg::ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]            wdata,
  output logic [CNT_W-1:0]            rdata,
  output logic                        irq
);
  import ctmr_pkg::*;

  logic             rst_ni;
  logic [CNT_W-1:0] count;
  logic [CNT_W-1:0] cval;
  logic [TV_W-1:0]  tval;
  logic [REG_W-1:0] freq, kctl;
  ctl_t             ctl;
  logic             sel_freq, sel_kctl, sel_cval, sel_tval, sel_ctl;

  ctmr_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_ni)
  );

  always_comb begin
    sel_freq = wr_en && (addr == A_FREQ);
    sel_kctl = wr_en && (addr == A_KCTL);
    sel_cval = wr_en && (addr == A_CVAL);
    sel_tval = wr_en && (addr == A_TVAL);
    sel_ctl  = wr_en && (addr == A_CTL);
  end

  ctmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_ni(rst_ni), .cnt_en(cnt_en), .count(count)
  );

  ctmr_cfgregs #(.REG_W(REG_W)) u_cfg (
    .clk(clk), .rst_ni(rst_ni),
    .freq_wr(sel_freq), .kctl_wr(sel_kctl),
    .wdata(wdata[REG_W-1:0]),
    .freq(freq), .kctl(kctl)
  );

  ctmr_compare #(.CNT_W(CNT_W), .TV_W(TV_W)) u_cmp (
    .clk(clk), .rst_ni(rst_ni), .count(count),
    .cval_wr(sel_cval), .tval_wr(sel_tval), .ctl_wr(sel_ctl),
    .wdata(wdata), .cval(cval), .tval(tval), .ctl(ctl), .irq(irq)
  );

  always_comb begin
    case (addr)
      A_FREQ:  rdata = CNT_W'(freq);
      A_KCTL:  rdata = CNT_W'(kctl);
      A_CVAL:  rdata = cval;
      A_TVAL:  rdata = CNT_W'(tval);
      A_CTL:   rdata = CNT_W'(ctl);
      A_COUNT: rdata = count;
      default: rdata = '0;
    endcase
  end

  AST_COUNT_RO: assert property (@(posedge clk) disable iff (!rst_ni)
    (wr_en && (addr == A_COUNT) && !cnt_en) |=> $stable(count)); // R8
  AST_SPARE_ZERO: assert property (@(posedge clk) disable iff (!rst_ni)
    (addr > A_COUNT) |-> (rdata == '0)); // R9

endmodule

// File: tb/sim_core_cmp_timer.sv
`timescale 1ns/1ps
module sim_core_cmp_timer;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cnt_en, wr_en;
  logic [3:0]  addr;
  logic [63:0] wdata;
  logic [63:0] rdata;
  logic        irq;

  int n_chk = 0;
  int n_fail = 0;
  logic [63:0] cur;   // bench model of the count
  logic [63:0] got;

  always #2.5 clk = ~clk;

  core_cmp_timer u0 (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [63:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [63:0] d);
    addr = a;
    #0.5;
    d = rdata;
  endtask

  task automatic tick(input int n);
    @(negedge clk);
    cnt_en = 1'b1;
    repeat (n) @(negedge clk);
    cnt_en = 1'b0;
    @(negedge clk);
    cur = cur + 64'(n);
  endtask

  initial begin
    #1_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cnt_en = 1'b0; wr_en = 1'b0; addr = '0; wdata = '0;
    cur = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset values
    rd(4'd0, got); chk("R1 freq", got, 64'h0180_0000);
    rd(4'd1, got); chk("R1 kctl", got, 64'd0);
    rd(4'd2, got); chk("R1 cval", got, 64'd0);
    rd(4'd5, got); chk("R1 count", got, 64'd0);
    rd(4'd4, got); chk("R1 ctl en/mask", got & 64'h3, 64'd0);

    // R3 absolute compare ahead of count clears status
    wr(4'd2, 64'd10);
    rd(4'd2, got); chk("R3 cval readback", got, 64'd10);
    rd(4'd4, got); chk("R3 status clear", got, 64'd0);

    // R2 counter stepping
    tick(9);
    rd(4'd5, got); chk("R2 count after 9", got, 64'd9);
    repeat (3) @(negedge clk);
    rd(4'd5, got); chk("R2 count holds", got, 64'd9);
    rd(4'd4, got); chk("R5 not yet reached", got, 64'd0);

    // R5 reach while disabled
    tick(1);
    rd(4'd4, got); chk("R5 status set disabled", got, 64'h4);
    chk("R6 irq off when disabled", {63'd0, irq}, 64'd0);

    // R6 exhaustive control codes with status set
    for (int v = 0; v < 8; v++) begin
      wr(4'd4, 64'(v));
      chk("R6 irq status=1", {63'd0, irq}, {63'd0, (v & 1) == 1 && (v & 2) == 0});
      rd(4'd4, got);
      chk("R7 ctl readback status=1", got, 64'(4 | (v & 3)));
    end

    // R7 control write with bit2 clear leaves status
    wr(4'd4, 64'd0);
    rd(4'd4, got); chk("R7 status kept", got, 64'h4);

    // R3 compare below count keeps status; far above clears
    wr(4'd2, 64'd5);
    rd(4'd4, got); chk("R3 status cmp below", got, 64'h4);
    wr(4'd2, 64'd100);
    rd(4'd4, got); chk("R3 status cmp above", got, 64'h0);

    // R6 exhaustive with status clear; R7 bit2 write does not set status
    for (int v = 0; v < 8; v++) begin
      wr(4'd4, 64'(v));
      chk("R6 irq status=0", {63'd0, irq}, 64'd0);
      rd(4'd4, got);
      chk("R7 ctl readback status=0", got, 64'(v & 3));
    end
    wr(4'd4, 64'd1);

    // R4 delta sweep
    for (int d = -8; d <= 8; d++) begin
      logic [63:0] expc;
      logic [31:0] d32;
      d32  = 32'(d);
      expc = cur + {{32{d32[31]}}, d32};
      wr(4'd3, {32'hA5A5_A5A5, d32});
      rd(4'd2, got); chk("R4 cval from delta", got, expc);
      rd(4'd3, got); chk("R4 tval readback", got, {32'd0, d32});
      rd(4'd4, got); chk("R4 status on delta", got, {61'd0, d <= 0, 2'b01});
      chk("R6 irq on delta", {63'd0, irq}, {63'd0, d <= 0});
    end

    // R4 tval tracks count
    wr(4'd3, 64'd20);
    tick(3);
    rd(4'd3, got); chk("R4 tval after 3", got, 64'd17);
    rd(4'd4, got); chk("R5 not reached", got, 64'h1);
    tick(17);
    rd(4'd4, got); chk("R5 reached via delta", got, 64'h5);
    chk("R6 irq asserted", {63'd0, irq}, 64'd1);
    tick(2);
    rd(4'd3, got); chk("R4 tval negative", got, 64'hFFFF_FFFE);
    rd(4'd4, got); chk("R5 status sticky", got, 64'h5);

    // R10 storage registers
    wr(4'd0, 64'hFFFF_0000_1234_5678);
    rd(4'd0, got); chk("R10 freq", got, 64'h1234_5678);
    wr(4'd1, 64'h0000_0000_8000_00C3);
    rd(4'd1, got); chk("R10 kctl", got, 64'h8000_00C3);

    // R8 count write ignored
    wr(4'd5, 64'hDEAD_BEEF);
    rd(4'd5, got); chk("R8 count unchanged", got, cur);

    // R9 spare addresses
    wr(4'd2, 64'h0123_4567_89AB_CDEF);
    for (int a = 6; a < 16; a++) begin
      wr(4'(a), '1);
      rd(4'(a), got); chk("R9 spare reads zero", got, 64'd0);
    end
    rd(4'd0, got); chk("R9 freq intact", got, 64'h1234_5678);
    rd(4'd1, got); chk("R9 kctl intact", got, 64'h8000_00C3);
    rd(4'd2, got); chk("R9 cval intact", got, 64'h0123_4567_89AB_CDEF);
    rd(4'd4, got); chk("R9 ctl intact", got, 64'h1);
    rd(4'd5, got); chk("R9 count intact", got, cur);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule